// File: doc/BRIEF.md
# Pulse-Coded Serial Converter Readout Sequencer

This block runs the host side of a 12-bit serial analog-to-digital converter. The converter has no chip select and no busy flag. The host picks the input channel, or the polarity, through the pattern of pulses it sends on the conversion-start line:

- A single rising edge asks for the first choice: channel one, or unipolar.
- A short high-low pulse followed by a second rise asks for the second choice: channel two, or bipolar.

The sequencer then holds the start line high for the acquisition window and drops it to begin the conversion. It waits a fixed conversion interval, because nothing on the wire reports completion.

It then reads the result with a serial clock in mode 0. The clock idles low, and data is captured on rising edges. The result arrives MSB first and can be read in one of two ways:

- one continuous burst, or
- two 8-clock bursts with a short idle gap between them.

Only the first 12 captured bits are kept. The result is presented as a 16-bit word, sign-extended when the second (bipolar) choice was requested. It comes with a one-cycle valid strobe.

All intervals are parameters counted in system-clock cycles. They must be chosen so that each one meets its minimum: pulse phases of 30 ns, acquisition of 1.4 µs, conversion of 3.7 µs, and serial clock phases of 38 ns with a clock of at most 8 MHz.

Top module: `adc_pulse_reader`

## Requirements
- R1: After reset, and whenever the block is idle, `cnvst` and `sclk` are low and `busy` and `valid` are low.
- R2: A `start` with `dual_sel`=0 produces exactly one `cnvst` rise. `cnvst` then stays high for exactly ACQ_CYC cycles before it falls.
- R3: A `start` with `dual_sel`=1 produces this sequence on `cnvst`:
  - high for PULSE_CYC cycles,
  - low for PULSE_CYC cycles,
  - a second rise,
  - high for ACQ_CYC cycles,
  - a fall.
- R4: `sclk` never rises while `cnvst` is high. The first `sclk` rise comes at least CONV_CYC cycles after `cnvst` falls.
- R5: Each `sclk` high phase and each in-burst low phase lasts exactly SCLK_HALF cycles. A single-burst readout issues SINGLE_CLKS rising edges, with 12 ≤ SINGLE_CLKS ≤ 16.
- R6: `sdo` is sampled on each `sclk` rise, MSB first. The first 12 bits form the result, with the first bit as result bit 11. Any later bits are discarded.
- R7: With `byte_mode`=1, the readout is two bursts of 8 clocks, 16 in total. The low phase before the 9th rise lasts BYTE_GAP+SCLK_HALF cycles, and the result equals that of a single burst.
- R8: With `dual_sel`=1, `result[15:12]` copies `result[11]` (two's complement). With `dual_sel`=0, `result[15:12]` is zero (straight binary).
- R9: `busy` is high from the cycle after an accepted `start` through the `valid` cycle. A `start` while `busy` is high is ignored: it causes no extra `cnvst` rise and does not change the result.
- R10: `valid` is a one-cycle pulse, and `result` holds its value after the pulse.
- R11: `cnvst` does not rise again once the readout clocks have begun. It rises only after a new `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Conversion request, accepted when idle |
| dual_sel | input | 1 | 1: double pulse (channel 2 / bipolar); 0: single pulse |
| byte_mode | input | 1 | 1: two 8-clock bursts; 0: one SINGLE_CLKS burst |
| cnvst | output | 1 | Conversion-start line to the converter |
| sclk | output | 1 | Serial clock, mode 0 |
| sdo | input | 1 | Serial data from the converter |
| busy | output | 1 | Sequence in progress |
| valid | output | 1 | One-cycle result strobe |
| result | output | 16 | Extended 12-bit result |

## Verification
The assertions assume two things about the inputs:
- `sdo` is only meaningful between `sclk` edges.
- `start`, `dual_sel` and `byte_mode` are synchronous to `clk`.

The bench stays within these assumptions. It drives every input one time unit after a falling clock edge. It plays the converter from the bench side: it loads the next data bit on each `sclk` fall and resets its bit pointer on each `cnvst` fall. As a result, `sdo` is always stable across the rising edge at which the sequencer samples it. Repeat requests are issued only from idle, except in the one scenario that deliberately pulses `start` while `busy` is high.

// File: rtl/adc_pulse_reader.sv
module adc_pulse_reader #(
  parameter int RES_BITS    = 12,
  parameter int WORD_BITS   = 16,
  parameter int BYTE_BITS   = 8,
  parameter int SINGLE_CLKS = 16,
  parameter int PULSE_CYC   = 6,
  parameter int ACQ_CYC     = 280,
  parameter int CONV_CYC    = 740,
  parameter int SCLK_HALF   = 13,
  parameter int BYTE_GAP    = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic                 dual_sel,
  input  logic                 byte_mode,
  output logic                 cnvst,
  output logic                 sclk,
  input  logic                 sdo,
  output logic                 busy,
  output logic                 valid,
  output logic [WORD_BITS-1:0] result
);
  localparam int M1   = (ACQ_CYC > CONV_CYC) ? ACQ_CYC : CONV_CYC;
  localparam int M2   = (PULSE_CYC > SCLK_HALF) ? PULSE_CYC : SCLK_HALF;
  localparam int M3   = (M2 > BYTE_GAP) ? M2 : BYTE_GAP;
  localparam int TMAX = (M1 > M3) ? M1 : M3;
  localparam int TW   = $clog2(TMAX + 1);
  localparam int NW   = $clog2(WORD_BITS + 1);
  localparam int EXT  = WORD_BITS - RES_BITS;

  typedef enum logic [3:0] {
    S_IDLE, S_PRE_HI, S_PRE_LO, S_ACQ, S_CONV, S_SLO, S_SHI, S_GAP, S_DONE
  } state_t;

  state_t              st;
  logic [TW-1:0]       tmr;
  logic [NW-1:0]       nbit;
  logic [RES_BITS-1:0] shreg;
  logic                dual_q, byte_q;

  wire             tdone   = (tmr == '0);
  wire [NW-1:0]    nbit_nx = nbit + 1'b1;
  wire             last_clk = byte_q ? (nbit_nx == NW'(2 * BYTE_BITS))
                                     : (nbit_nx == NW'(SINGLE_CLKS));
  wire             byte_brk = byte_q && (nbit_nx == NW'(BYTE_BITS));
  wire             keep_bit = (nbit < NW'(RES_BITS));
  wire [RES_BITS-1:0] shnext = {shreg[RES_BITS-2:0], sdo};
  wire [WORD_BITS-1:0] ext_word = {{EXT{dual_q & shreg[RES_BITS-1]}}, shreg};

  assign busy  = (st != S_IDLE);
  assign valid = (st == S_DONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      tmr    <= '0;
      nbit   <= '0;
      shreg  <= '0;
      dual_q <= 1'b0;
      byte_q <= 1'b0;
      cnvst  <= 1'b0;
      sclk   <= 1'b0;
      result <= '0;
    end else begin
      case (st)
        S_IDLE: begin
          if (start) begin
            dual_q <= dual_sel;
            byte_q <= byte_mode;
            nbit   <= '0;
            cnvst  <= 1'b1;
            if (dual_sel) begin
              st  <= S_PRE_HI;
              tmr <= TW'(PULSE_CYC - 1);
            end else begin
              st  <= S_ACQ;
              tmr <= TW'(ACQ_CYC - 1);
            end
          end
        end
        S_PRE_HI: begin
          if (tdone) begin
            cnvst <= 1'b0;
            tmr   <= TW'(PULSE_CYC - 1);
            st    <= S_PRE_LO;
          end else tmr <= tmr - 1'b1;
        end
        S_PRE_LO: begin
          if (tdone) begin
            cnvst <= 1'b1;
            tmr   <= TW'(ACQ_CYC - 1);
            st    <= S_ACQ;
          end else tmr <= tmr - 1'b1;
        end
        S_ACQ: begin
          if (tdone) begin
            cnvst <= 1'b0;
            tmr   <= TW'(CONV_CYC - 1);
            st    <= S_CONV;
          end else tmr <= tmr - 1'b1;
        end
        S_CONV: begin
          if (tdone) begin
            tmr <= TW'(SCLK_HALF - 1);
            st  <= S_SLO;
          end else tmr <= tmr - 1'b1;
        end
        S_SLO: begin
          if (tdone) begin
            sclk <= 1'b1;
            if (keep_bit) shreg <= shnext;
            tmr  <= TW'(SCLK_HALF - 1);
            st   <= S_SHI;
          end else tmr <= tmr - 1'b1;
        end
        S_SHI: begin
          if (tdone) begin
            sclk <= 1'b0;
            nbit <= nbit_nx;
            if (last_clk) begin
              result <= ext_word;
              st     <= S_DONE;
            end else if (byte_brk) begin
              tmr <= TW'(BYTE_GAP - 1);
              st  <= S_GAP;
            end else begin
              tmr <= TW'(SCLK_HALF - 1);
              st  <= S_SLO;
            end
          end else tmr <= tmr - 1'b1;
        end
        S_GAP: begin
          if (tdone) begin
            tmr <= TW'(SCLK_HALF - 1);
            st  <= S_SLO;
          end else tmr <= tmr - 1'b1;
        end
        S_DONE:  st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/adc_pulse_reader_chk.sv
module adc_pulse_reader_chk #(
  parameter int RES_BITS  = 12,
  parameter int WORD_BITS = 16,
  parameter int CONV_CYC  = 740
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 cnvst,
  input logic                 sclk,
  input logic                 busy,
  input logic                 valid,
  input logic [WORD_BITS-1:0] result
);
  localparam int CW = $clog2(CONV_CYC + 1);
  localparam int RW = $clog2(WORD_BITS + 2);

  logic [CW-1:0] since_fall;
  logic [RW-1:0] rises;
  logic          sclk_d, cnv_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_fall <= '0;
      rises      <= '0;
      sclk_d     <= 1'b0;
      cnv_d      <= 1'b0;
    end else begin
      sclk_d <= sclk;
      cnv_d  <= cnvst;
      if (cnvst) since_fall <= '0;
      else if (since_fall != CW'(CONV_CYC)) since_fall <= since_fall + 1'b1;
      if (!busy) rises <= '0;
      else if (sclk && !sclk_d && rises != RW'(WORD_BITS + 1)) rises <= rises + 1'b1;
    end
  end

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!cnvst && !sclk && !valid));
  assert_no_sclk_in_acq_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cnvst |-> !sclk);
  assert_conv_wait_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk && !sclk_d) |-> (since_fall >= CW'(CONV_CYC)));
  assert_clock_count_R5: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> (rises >= RW'(RES_BITS) && rises <= RW'(WORD_BITS)));
  assert_extension_R8: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> (result[WORD_BITS-1:RES_BITS] == '0 || (&result[WORD_BITS-1:RES_BITS-1])));
  assert_valid_in_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> busy);
  assert_valid_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    valid |=> (!valid && $stable(result)));
  assert_no_late_cnv_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (cnvst && !cnv_d) |-> (rises == '0));
endmodule

bind adc_pulse_reader adc_pulse_reader_chk #(
  .RES_BITS(RES_BITS), .WORD_BITS(WORD_BITS), .CONV_CYC(CONV_CYC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cnvst(cnvst), .sclk(sclk),
  .busy(busy), .valid(valid), .result(result)
);

// File: tb/tb_adc_pulse_reader.sv
`timescale 1ns/1ps
module tb_adc_pulse_reader;
  localparam int PULSE = 6, ACQ = 280, CONV = 740, SH = 13, GAP = 16, SINGLE = 16;

  logic clk = 0, rst_n = 0, start = 0, dual_sel = 0, byte_mode = 0;
  logic cnvst, sclk, busy, valid;
  logic [15:0] result;
  logic [11:0] slave_code = '0;
  int idx = 16;
  wire [15:0] sw = {slave_code, 4'hA};
  wire sdo = (idx < 16) ? sw[15 - idx] : 1'b0;

  int errors = 0, checks = 0;

  always #2.5 clk = ~clk;

  adc_pulse_reader dut (
    .clk(clk), .rst_n(rst_n), .start(start), .dual_sel(dual_sel),
    .byte_mode(byte_mode), .cnvst(cnvst), .sclk(sclk), .sdo(sdo),
    .busy(busy), .valid(valid), .result(result)
  );

  // monitor and converter model
  logic cnv_p = 0, sclk_p = 0, busy_p = 0;
  int cnv_rises, hi0, lo0, hi1, cnv_cnt, sck_cnt, conv_w, since_fall;
  int sck_rises, min_hi, min_lo, max_lo, gap_at;
  always @(negedge clk) begin
    if (start && !busy_p) begin
      cnv_rises = 0; hi0 = 0; lo0 = 0; hi1 = 0; conv_w = -1;
      sck_rises = 0; min_hi = 9999; min_lo = 9999; max_lo = 0; gap_at = 0;
    end
    if (cnvst != cnv_p) begin
      if (cnvst) begin
        if (cnv_rises == 1) lo0 = cnv_cnt;
        cnv_rises++;
      end else begin
        if (cnv_rises == 1) hi0 = cnv_cnt; else hi1 = cnv_cnt;
        idx = 0; since_fall = 1;
      end
      cnv_cnt = 1;
    end else begin
      cnv_cnt++;
    end
    if (sclk != sclk_p) begin
      if (sclk) begin
        if (sck_rises == 0) conv_w = since_fall;
        else begin
          if (sck_cnt < min_lo) min_lo = sck_cnt;
          if (sck_cnt > max_lo) begin max_lo = sck_cnt; gap_at = sck_rises + 1; end
        end
        sck_rises++;
      end else begin
        if (sck_cnt < min_hi) min_hi = sck_cnt;
        idx++;
      end
      sck_cnt = 1;
    end else begin
      sck_cnt++;
    end
    since_fall++;
    cnv_p = cnvst; sclk_p = sclk; busy_p = busy;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d (0x%0h) expected=%0d (0x%0h)", req, act, act, exp, exp);
    end
  endtask

  task automatic issue(input bit d, input bit b, input logic [11:0] code);
    @(negedge clk); #1;
    slave_code = code; dual_sel = d; byte_mode = b; start = 1;
    @(negedge clk); #1;
    start = 0; dual_sel = 0; byte_mode = 0;
  endtask

  task automatic wait_valid(output bit got, output logic [15:0] res);
    got = 0; res = '0;
    for (int i = 0; i < 6000 && !got; i++) begin
      @(negedge clk);
      if (valid) begin got = 1; res = result; end
    end
  endtask

  task automatic run_conv(input bit d, input bit b, input logic [11:0] code, input string tag);
    bit got; logic [15:0] res, expv;
    int nclk;
    issue(d, b, code);
    wait_valid(got, res);
    chk(got, {tag, " valid seen"}, got, 1);
    expv = d ? {{4{code[11]}}, code} : {4'h0, code};
    nclk = b ? 16 : SINGLE;
    chk(res == expv, {tag, " R6 R8 result"}, res, expv);
    if (d) begin
      chk(cnv_rises == 2, "R3 two rises", cnv_rises, 2);
      chk(hi0 == PULSE && lo0 == PULSE, "R3 pre-pulse high", hi0, PULSE);
      chk(lo0 == PULSE, "R3 pre-pulse low", lo0, PULSE);
      chk(hi1 == ACQ, "R3 acquisition", hi1, ACQ);
    end else begin
      chk(cnv_rises == 1, "R2 one rise", cnv_rises, 1);
      chk(hi0 == ACQ, "R2 acquisition", hi0, ACQ);
    end
    chk(conv_w >= CONV, "R4 conversion wait", conv_w, CONV);
    chk(sck_rises == nclk, "R5 clock count", sck_rises, nclk);
    chk(min_hi == SH, "R5 high phase", min_hi, SH);
    chk(min_lo == SH, "R5 low phase", min_lo, SH);
    if (b) begin
      chk(max_lo == GAP + SH, "R7 byte gap length", max_lo, GAP + SH);
      chk(gap_at == 9, "R7 gap position", gap_at, 9);
    end else begin
      chk(max_lo == SH, "R7 no gap in single burst", max_lo, SH);
    end
    @(negedge clk);
    chk(!valid, "R10 valid one cycle", valid, 0);
    chk(result == expv, "R10 result held", result, expv);
    chk(!busy, "R9 busy released", busy, 0);
    chk(!cnvst && !sclk, "R1 idle lines", {cnvst, sclk}, 0);
  endtask

  task automatic t_reset();
    chk(!cnvst, "R1 cnvst reset", cnvst, 0);
    chk(!sclk, "R1 sclk reset", sclk, 0);
    chk(!busy, "R1 busy reset", busy, 0);
    chk(!valid, "R1 valid reset", valid, 0);
  endtask

  task automatic t_busy_block();
    bit got; logic [15:0] res;
    issue(0, 0, 12'h3C5);
    repeat (50) @(negedge clk);
    chk(busy, "R9 busy during acquisition", busy, 1);
    #1; start = 1; dual_sel = 1; byte_mode = 1;
    @(negedge clk); #1; start = 0; dual_sel = 0; byte_mode = 0;
    repeat (1100) @(negedge clk);
    chk(busy, "R9 busy during readout", busy, 1);
    #1; start = 1;
    @(negedge clk); #1; start = 0;
    wait_valid(got, res);
    chk(got && res == 16'h03C5, "R9 ignored start keeps result", res, 16'h03C5);
    chk(cnv_rises == 1, "R9 R11 no extra cnvst rise", cnv_rises, 1);
    chk(sck_rises == SINGLE, "R9 format unchanged", sck_rises, SINGLE);
    repeat (20) @(negedge clk);
    chk(!cnvst && !busy, "R11 stays idle without start", {cnvst, busy}, 0);
  endtask

  bit finished = 0;
  initial begin
    #(200000 * 5);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    #1 rst_n = 1;
    repeat (3) @(negedge clk);
    t_reset();
    run_conv(0, 0, 12'hA5C, "single unipolar");
    run_conv(1, 0, 12'h800, "dual negative");
    run_conv(1, 0, 12'h7FF, "dual positive");
    run_conv(0, 0, 12'hFFF, "unipolar full scale");
    run_conv(0, 1, 12'h5A3, "byte unipolar");
    run_conv(1, 1, 12'hC01, "byte bipolar");
    run_conv(0, 1, 12'h000, "byte zero");
    t_busy_block();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule